// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable model of a single-port synchronous SRAM whose bus can alternate between reads and writes every cycle with no idle slot. The command (address, direction, byte masks) is captured on one rising edge. The matching data beat happens exactly two effective edges later. Write data is taken from `dq_in`, and read data appears on `dq_out` with `dq_oe` raised. Because write data trails its command by the same two cycles as read data, a read followed by a write, or a write followed by a read, never collides on the bus.

A 2-bit burst counter lets one loaded address produce four beats in linear or interleaved order. The order is picked by a static pin. An active-low clock enable and a sleep input both freeze the whole block as if the edge never happened. Three chip selects gate new commands. A deselect ends any burst but lets commands already in the pipeline finish. The tri-state bus is split into an input, an output and an output-enable, and an asynchronous active-low output enable can force the driver off.

Top module: `zbt_sram`

## Requirements
- R1: A read command captured on effective edge k puts the array word on `dq_out` with `dq_oe` high after effective edge k+2. A write command captured on edge k stores the `dq_in` value present at edge k+2.
- R2: While `cen_n` is high, an edge changes nothing: no command is captured, the pipeline does not move, no array write occurs, and `dq_out`/`dq_oe` hold.
- R3: With `adv_ld` low and the chip selected, `addr` and `rd_nwr` (1 = read, 0 = write) start a new operation. Reads and writes may alternate on consecutive cycles.
- R4: The chip is selected only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. An edge with `adv_ld` low while unselected starts no operation and ends any burst. Operations already issued still complete.
- R5: `dq_oe` is low after the edge at which a deselect or a write command reaches its data slot (two effective edges after it was issued).
- R6: With `adv_ld` high during a burst, the next beat uses the same upper address bits. The low two bits are (start + n) mod 4 when `burst_ilv`=0, or start XOR n when `burst_ilv`=1, for beat n = 1, 2, 3, 0, and so on. Each beat keeps the load cycle's direction. With no burst active, `adv_ld` high starts nothing.
- R7: `bw_n[i]` low enables byte i (bits 9i+8..9i) of a write. It is sampled with each write beat, including burst beats. Unselected bytes keep their value, and `bw_n` is ignored for reads.
- R8: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R9: `sleep` high freezes the block exactly as `cen_n` high does, and array contents are kept.
- R10: A read issued on the cycle right after a write to the same address returns the newly written, byte-merged data.
- R11: Synchronous active-high `rst` clears pending operations and the burst state, so `dq_oe` stays low until a new read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Sleep, freezes the block when high |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rd_nwr | input | 1 | Direction of a load: 1 read, 0 write |
| burst_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| bw_n | input | BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | BYTES*BYTE_W | Write data bus |
| dq_out | output | BYTES*BYTE_W | Read data bus |
| dq_oe | output | 1 | High while `dq_out` should be driven |

## Verification
A stimulus table is replayed once with linear burst order and once with interleaved order. In linear order a burst started at low bits 2 or 3 visits 3,0,1 or 0,1,2. In interleaved order it visits 3,0,1 and 2,1,0, which separates the two orderings. The table mixes alternating reads and writes, a partial byte write followed at once by a read, stalls and a sleep with conflicting junk on the inputs, and stalls in the middle of a burst. It also includes deselects on each chip select, an advance with no burst active, and `oe_n` raised over a read beat. Each pattern is compared against a behavioural memory that tracks bytes known to have been written. Directed cases toggle `oe_n` between edges to show the gate is asynchronous, and apply reset while a read is in flight.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES = 2,
  parameter int BYTE_W = 9,
  localparam int DW = BYTES * BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              sleep,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  input  logic              adv_ld,
  input  logic              rd_nwr,
  input  logic              burst_ilv,
  input  logic              oe_n,
  input  logic [BYTES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic              b_act, b_wr;
  logic [1:0]        b_base, b_cnt;
  logic [ADDR_W-3:0] b_up;

  logic              s1_v, s1_wr, s2_v, s2_wr, rd_vld;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [BYTES-1:0]  s1_bw, s2_bw;
  logic [DW-1:0]     dout;

  wire tick = !cen_n && !sleep;
  wire sel  = !cs1_n && !cs2_n && cs3;
  wire load = !adv_ld && sel;

  wire [1:0] nxt_cnt = b_cnt + 2'd1;
  wire [1:0] adv_lo  = burst_ilv ? (b_base ^ nxt_cnt) : (b_base + nxt_cnt);

  wire              op_v  = load || (adv_ld && b_act);
  wire              op_wr = load ? !rd_nwr : b_wr;
  wire [ADDR_W-1:0] op_a  = load ? addr : {b_up, adv_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_cnt  <= '0;
      b_base <= '0;
      b_up   <= '0;
      s1_v   <= 1'b0;
      s1_wr  <= 1'b0;
      s1_a   <= '0;
      s1_bw  <= '1;
      s2_v   <= 1'b0;
      s2_wr  <= 1'b0;
      s2_a   <= '0;
      s2_bw  <= '1;
      rd_vld <= 1'b0;
      dout   <= '0;
    end else if (tick) begin
      if (!adv_ld) begin
        b_act  <= sel;
        b_wr   <= !rd_nwr;
        b_base <= addr[1:0];
        b_up   <= addr[ADDR_W-1:2];
        b_cnt  <= '0;
      end else if (b_act) begin
        b_cnt <= nxt_cnt;
      end
      s1_v   <= op_v;
      s1_wr  <= op_wr;
      s1_a   <= op_a;
      s1_bw  <= bw_n;
      s2_v   <= s1_v;
      s2_wr  <= s1_wr;
      s2_a   <= s1_a;
      s2_bw  <= s1_bw;
      rd_vld <= s2_v && !s2_wr;
      if (s2_v && !s2_wr) dout <= mem[s2_a];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && tick && s2_v && s2_wr) begin
      for (int i = 0; i < BYTES; i++)
        if (!s2_bw[i]) mem[s2_a][i*BYTE_W +: BYTE_W] <= dq_in[i*BYTE_W +: BYTE_W];
    end
  end

  assign dq_out = dout;
  assign dq_oe  = rd_vld && !oe_n;

  assert_cmd_capture_R3: assert property (@(posedge clk) disable iff (rst)
    tick && load |=> s1_v && (s1_wr == !$past(rd_nwr)) && (s1_a == $past(addr)))
    else $error("load not captured");

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(s1_v) && $stable(s2_v) && $stable(rd_vld) && $stable(dout) && $stable(b_act))
    else $error("state moved during stall");

  assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    tick && !adv_ld && !sel |=> !s1_v && !b_act)
    else $error("deselect started an operation");

  assert_burst_beat_R6: assert property (@(posedge clk) disable iff (rst)
    tick && adv_ld && b_act |=> s1_v && (s1_wr == $past(b_wr)) && (s1_a[ADDR_W-1:2] == $past(b_up)))
    else $error("burst beat lost direction or upper address");

  assert_bus_release_R5: assert property (@(posedge clk) disable iff (rst)
    tick && s2_v && s2_wr |=> !dq_oe)
    else $error("bus driven in a write data slot");

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BWD = 9;
  localparam int DW = NB * BWD;
  localparam int NV = 23;

  // vector: cen_n sleep cs1_n cs2_n cs3 adv_ld rd_nwr oe_n bw_n[1:0] addr[5:0]
  localparam logic [15:0] IDLE = 16'b0_0_1_0_1_0_1_0_11_000000;
  localparam logic [15:0] TBL [NV] = '{
    16'b0_0_0_0_1_0_0_0_00_000101,
    16'b0_0_0_0_1_0_0_0_00_000110,
    16'b0_0_0_0_1_0_1_0_11_000101,
    16'b0_0_0_0_1_0_0_0_01_000101,
    16'b0_0_0_0_1_0_1_0_11_000101,
    16'b1_0_0_0_1_0_0_0_00_001111,
    16'b0_0_0_0_1_0_1_0_11_000110,
    16'b0_1_0_0_1_0_0_0_00_000110,
    16'b0_0_0_0_1_0_0_0_00_001010,
    16'b0_0_0_0_1_1_1_0_00_111111,
    16'b0_0_0_0_1_1_1_0_10_111111,
    16'b0_0_0_0_1_1_1_0_00_111111,
    16'b0_0_0_0_1_0_1_0_11_001011,
    16'b0_0_0_0_1_1_0_0_00_000000,
    16'b1_0_0_0_1_1_0_0_00_000000,
    16'b0_0_0_0_1_1_0_0_00_000000,
    16'b0_0_0_0_1_1_0_0_00_000000,
    16'b0_0_0_1_1_0_1_0_11_000000,
    16'b0_0_0_0_1_1_1_0_11_000000,
    16'b0_0_0_0_1_0_1_0_11_001010,
    16'b0_0_0_0_0_0_1_0_11_000000,
    16'b0_0_1_0_1_0_1_1_11_000000,
    16'b0_0_1_0_1_0_1_0_11_000000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cen_n = 1'b0, sleep = 1'b0, cs1_n = 1'b1, cs2_n = 1'b0, cs3 = 1'b1;
  logic adv_ld = 1'b0, rd_nwr = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #2.5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BWD)) dut_i (
    .clk(clk), .rst(rst), .cen_n(cen_n), .sleep(sleep), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .cs3(cs3), .adv_ld(adv_ld), .rd_nwr(rd_nwr), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .bw_n(bw_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] mm [1<<AW];
  logic [NB-1:0] mk [1<<AW];
  logic m1v, m1w, m2v, m2w;
  logic [AW-1:0] m1a, m2a;
  logic [NB-1:0] m1b, m2b;
  logic ba, bwr;
  logic [1:0] bbase, bcnt;
  logic [AW-3:0] bup;
  logic eoe = 1'b0;
  logic [DW-1:0] eout = '0;
  logic [NB-1:0] eknown = '0;
  string last_tag = "R11 reset";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    logic eon;
    bit ok;
    eon = eoe && !oe_n;
    chk(dq_oe === eon, {tag, " dq_oe"}, {31'd0, dq_oe}, {31'd0, eon});
    if (eon) begin
      ok = 1'b1;
      for (int i = 0; i < NB; i++)
        if (eknown[i] && dq_out[i*BWD +: BWD] !== eout[i*BWD +: BWD]) ok = 1'b0;
      chk(ok, {tag, " dq_out"}, {14'd0, dq_out}, {14'd0, eout});
    end
  endtask

  task automatic clear_model();
    m1v = 1'b0; m2v = 1'b0; ba = 1'b0; eoe = 1'b0;
    m1w = 1'b0; m2w = 1'b0; m1a = '0; m2a = '0; m1b = '1; m2b = '1;
  endtask

  task automatic apply(input logic [15:0] v);
    logic sel, nv, nw;
    logic [AW-1:0] na;
    logic [1:0] lo;
    {cen_n, sleep, cs1_n, cs2_n, cs3, adv_ld, rd_nwr, oe_n, bw_n, addr} = v;
    cyc++;
    dq_in = {cyc[8:0] ^ 9'h1a5, cyc[8:0] + 9'h033};
    if (!cen_n && !sleep) begin
      if (m2v && m2w) begin
        for (int i = 0; i < NB; i++)
          if (!m2b[i]) begin
            mm[m2a][i*BWD +: BWD] = dq_in[i*BWD +: BWD];
            mk[m2a][i] = 1'b1;
          end
      end
      if (m2v && !m2w) begin
        eoe = 1'b1; eout = mm[m2a]; eknown = mk[m2a];
      end else eoe = 1'b0;
      sel = !cs1_n && !cs2_n && cs3;
      nv = 1'b0; nw = 1'b0; na = '0;
      if (!adv_ld) begin
        if (sel) begin
          nv = 1'b1; nw = !rd_nwr; na = addr;
          ba = 1'b1; bwr = !rd_nwr; bbase = addr[1:0]; bup = addr[AW-1:2]; bcnt = 2'd0;
        end else ba = 1'b0;
      end else if (ba) begin
        bcnt = bcnt + 2'd1;
        lo = burst_ilv ? (bbase ^ bcnt) : (bbase + bcnt);
        nv = 1'b1; nw = bwr; na = {bup, lo};
      end
      m2v = m1v; m2w = m1w; m2a = m1a; m2b = m1b;
      m1v = nv; m1w = nw; m1a = na; m1b = bw_n;
    end
  endtask

  task automatic step(input logic [15:0] v, input string tag);
    @(negedge clk);
    check_out(last_tag);
    apply(v);
    last_tag = tag;
  endtask

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    check_out(last_tag);
    rst = 1'b1;
    {cen_n, sleep, cs1_n, cs2_n, cs3, adv_ld, rd_nwr, oe_n, bw_n, addr} = IDLE;
    burst_ilv = ilv;
    clear_model();
    @(negedge clk);
    @(negedge clk);
    chk(dq_oe === 1'b0, "R11 reset dq_oe", {31'd0, dq_oe}, 32'd0);
    rst = 1'b0;
    apply(IDLE);
    last_tag = "R11 after reset";
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin mm[a] = '0; mk[a] = '0; end
    clear_model();
    do_reset(1'b0);
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) do_reset(1'b1);
      for (int i = 0; i < NV; i++)
        step(TBL[i], "R1 R2 R3 R4 R5 R6 R7 R9 R10 table");
      for (int i = 0; i < 3; i++) step(IDLE, "R5 idle");
    end
    // R8: asynchronous output gate over a read beat
    step(16'b0_0_0_0_1_0_1_0_11_000110, "R8 read");
    step(IDLE, "R8 wait");
    step(IDLE, "R8 wait");
    @(posedge clk);
    #1;
    chk(dq_oe === 1'b1, "R8 beat driven", {31'd0, dq_oe}, 32'd1);
    oe_n = 1'b1;
    #0.5;
    chk(dq_oe === 1'b0, "R8 oe_n high", {31'd0, dq_oe}, 32'd0);
    oe_n = 1'b0;
    #0.5;
    chk(dq_oe === 1'b1, "R8 oe_n low", {31'd0, dq_oe}, 32'd1);
    // R11: reset with a read in flight
    step(16'b0_0_0_0_1_0_1_0_11_000101, "R11 read before reset");
    do_reset(1'b1);
    for (int i = 0; i < 3; i++) step(IDLE, "R11 no stale read");
    step(IDLE, "R4 idle");
    @(negedge clk);
    check_out(last_tag);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule